// File: doc/BRIEF.md
# Minimal Machine-Mode CSR Unit

This block is a reduced machine-mode control and status register file for a small 32-bit integer core. The core presents one CSR access per cycle as an operation code, a 12-bit address and an operand. The block returns the register's current value in the same cycle. At the clock edge it applies the write, set or clear. Only a handful of registers exist. Every other address reads as zero, and writes to such an address are discarded.

When the core takes an exception, it raises a trap strobe together with the faulting PC, the cause and the trap value, and the block latches all three. The trap entry address is a fixed constant. The resume address that the core uses for a return-from-trap comes straight from the saved exception PC. Three 64-bit read-only counters are visible: cycles, time and retired instructions. Cycles and time are one shared register.

Top module: `mcsr_unit`

## Requirements
- R1: After reset, scratch, exception PC, cause, trap value and all counters read as zero.
- R2: Any address other than 0x305, 0x340-0x343, 0xC00-0xC02 and 0xC80-0xC82 reads as zero, and a write to it changes no implemented register.
- R3: Address 0x305 (trap entry) always reads the constant TRAP_VEC (default 0x0000_0100), and writes to it have no effect.
- R4: Address 0x340 is a 32-bit scratch register. Operation codes are 01 (write), 10 (set bits) and 11 (clear bits); code 00 is a read only. The read data is the value before the update.
- R5: The exception PC at 0x341 keeps bits [1:0] at zero after any software write or trap capture.
- R6: A trap strobe stores the PC with bits [1:0] cleared into 0x341, the cause into 0x342 and the trap value into 0x343, visible in the following cycle.
- R7: When a trap strobe and a software write to 0x341-0x343 fall in the same cycle, the trap values are kept.
- R8: The resume_pc output always equals the stored exception PC.
- R9: One counter serves both the cycle and the time views. It advances by one every clock. Its low word reads at 0xC00 and 0xC01, and its high word at 0xC80 and 0xC81.
- R10: The retired-instruction counter (low word 0xC02, high word 0xC82) advances by one in each cycle where retire is high.
- R11: A counter read returns the value from before any increment in that cycle, and software writes to counter addresses are ignored.
- R12: Set or clear with an all-zero operand performs no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | CSR access valid this cycle |
| csr_op | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Operand (register value or immediate) |
| csr_rdata | output | 32 | Value before update |
| trap_valid | input | 1 | Exception taken this cycle |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_cause | input | 32 | Cause code |
| trap_tval | input | 32 | Trap value |
| retire | input | 1 | One instruction retired this cycle |
| resume_pc | output | 32 | Return-from-trap target |
| trap_vector | output | 32 | Trap entry address |

## Verification
Two events can land on the same clock. A trap capture can coincide with a software write to the same trap register, and a counter read can coincide with that counter's increment. The bench drives a trap strobe and a write to the cause, trap value and exception PC in a single cycle, then reads each register back and expects the trap's values. For counters, it reads the retired count while retire is high and expects the old value. The next read must show exactly one more, and reads of the cycle and time views in consecutive cycles must differ by exactly one.

// File: rtl/mcsr_unit.sv
module mcsr_unit #(
  parameter logic [31:0] TRAP_VEC = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_en,
  input  logic [1:0]  csr_op,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        trap_valid,
  input  logic [31:0] trap_pc,
  input  logic [31:0] trap_cause,
  input  logic [31:0] trap_tval,
  input  logic        retire,
  output logic [31:0] resume_pc,
  output logic [31:0] trap_vector
);
  localparam logic [11:0] A_TVEC = 12'h305, A_SCR = 12'h340, A_EPC = 12'h341,
                          A_CAU = 12'h342, A_TVAL = 12'h343,
                          A_CYC = 12'hC00, A_TIM = 12'hC01, A_RET = 12'hC02,
                          A_CYCH = 12'hC80, A_TIMH = 12'hC81, A_RETH = 12'hC82;

  logic [31:0] scratch_q, mepc_q, mcause_q, mtval_q, upd;
  logic [63:0] cyc_q, ret_q;
  logic        wr;

  always_comb begin
    case (csr_addr)
      A_TVEC:         csr_rdata = TRAP_VEC;
      A_SCR:          csr_rdata = scratch_q;
      A_EPC:          csr_rdata = mepc_q;
      A_CAU:          csr_rdata = mcause_q;
      A_TVAL:         csr_rdata = mtval_q;
      A_CYC, A_TIM:   csr_rdata = cyc_q[31:0];
      A_CYCH, A_TIMH: csr_rdata = cyc_q[63:32];
      A_RET:          csr_rdata = ret_q[31:0];
      A_RETH:         csr_rdata = ret_q[63:32];
      default:        csr_rdata = '0;
    endcase
  end

  assign wr = csr_en && (csr_op == 2'b01 || (csr_op[1] && |csr_wdata));

  always_comb begin
    case (csr_op)
      2'b01:   upd = csr_wdata;
      2'b10:   upd = csr_rdata | csr_wdata;
      2'b11:   upd = csr_rdata & ~csr_wdata;
      default: upd = csr_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q <= '0;
      mepc_q    <= '0;
      mcause_q  <= '0;
      mtval_q   <= '0;
      cyc_q     <= '0;
      ret_q     <= '0;
    end else begin
      cyc_q <= cyc_q + 64'd1;
      if (retire) ret_q <= ret_q + 64'd1;
      if (wr && csr_addr == A_SCR) scratch_q <= upd;
      if (trap_valid) begin
        mepc_q   <= {trap_pc[31:2], 2'b00};
        mcause_q <= trap_cause;
        mtval_q  <= trap_tval;
      end else if (wr) begin
        if (csr_addr == A_EPC)  mepc_q   <= {upd[31:2], 2'b00};
        if (csr_addr == A_CAU)  mcause_q <= upd;
        if (csr_addr == A_TVAL) mtval_q  <= upd;
      end
    end
  end

  assign resume_pc   = mepc_q;
  assign trap_vector = TRAP_VEC;
endmodule

// File: rtl/mcsr_unit_sva.sv
module mcsr_unit_sva #(
  parameter logic [31:0] TRAP_VEC = 32'h0000_0100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_en,
  input logic [11:0] csr_addr,
  input logic [31:0] csr_rdata,
  input logic        trap_valid,
  input logic [31:0] trap_pc,
  input logic [31:0] trap_cause,
  input logic        retire,
  input logic [31:0] resume_pc,
  input logic [31:0] mcause_q,
  input logic [63:0] cyc_q,
  input logic [63:0] ret_q
);
  a_r5_epc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pc[1:0] == 2'b00);
  a_r7_trap_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (resume_pc == {$past(trap_pc[31:2]), 2'b00}) && (mcause_q == $past(trap_cause)));
  a_r3_vector_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == 12'h305) |-> csr_rdata == TRAP_VEC);
  a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == 12'h301) |-> csr_rdata == 32'd0);
  a_r9_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cyc_q == $past(cyc_q) + 64'd1);
  a_r10_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> ret_q == $past(ret_q) + 64'd1);
  a_r10_retire_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(ret_q));
endmodule

bind mcsr_unit mcsr_unit_sva #(.TRAP_VEC(TRAP_VEC)) u_sva (
  .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_addr(csr_addr),
  .csr_rdata(csr_rdata), .trap_valid(trap_valid), .trap_pc(trap_pc),
  .trap_cause(trap_cause), .retire(retire), .resume_pc(resume_pc),
  .mcause_q(mcause_q), .cyc_q(cyc_q), .ret_q(ret_q)
);

// File: tb/mcsr_unit_test.sv
`timescale 1ns/1ps
module mcsr_unit_test;
  logic clk = 0, rst_n = 0;
  logic csr_en = 0, trap_valid = 0, retire = 0;
  logic [1:0] csr_op = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, trap_pc = 0, trap_cause = 0, trap_tval = 0;
  logic [31:0] csr_rdata, resume_pc, trap_vector;
  int checks = 0, failures = 0;
  logic [31:0] m_scr = 0, m_epc = 0, m_cau = 0, m_tval = 0;

  always #2.5 clk = ~clk;

  mcsr_unit uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(logic [1:0] op, logic [11:0] a, logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    csr_en = 1; csr_op = op; csr_addr = a; csr_wdata = d;
    #1 rd = csr_rdata;
    @(posedge clk); #0.5;
    csr_en = 0; csr_op = 0;
  endtask

  function automatic bit is_impl(logic [11:0] a);
    return a == 12'h305 || (a >= 12'h340 && a <= 12'h343) ||
           (a >= 12'hC00 && a <= 12'hC02) || (a >= 12'hC80 && a <= 12'hC82);
  endfunction

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r, r2, r3;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    acc(2'b00, 12'h340, 0, r); chk("R1 scratch", r, 0);
    acc(2'b00, 12'h341, 0, r); chk("R1 epc", r, 0);
    acc(2'b00, 12'h342, 0, r); chk("R1 cause", r, 0);
    acc(2'b00, 12'h343, 0, r); chk("R1 tval", r, 0);
    acc(2'b00, 12'h0C82, 0, r); chk("R1 instret hi", r, 0);
    acc(2'b00, 12'h0C02, 0, r); chk("R1 instret lo", r, 0);
    acc(2'b00, 12'h0C00, 0, r); chk("R1 cycle small", {31'd0, r < 32'd20}, 1);
    // R4 scratch ops
    acc(2'b01, 12'h340, 32'hA5A5_0F0F, r); chk("R4 old on write", r, 0);
    acc(2'b10, 12'h340, 32'h0000_F000, r); chk("R4 old on set", r, 32'hA5A5_0F0F);
    acc(2'b11, 12'h340, 32'hA500_0000, r); chk("R4 old on set result", r, 32'hA5A5_FF0F);
    acc(2'b00, 12'h340, 32'hFFFF_FFFF, r); chk("R4 clear result", r, 32'h00A5_FF0F);
    acc(2'b00, 12'h340, 0, r); chk("R4 read op no write", r, 32'h00A5_FF0F);
    m_scr = 32'h00A5_FF0F;
    // R12 zero operand
    acc(2'b01, 12'h342, 32'h0000_0007, r);
    acc(2'b11, 12'h342, 0, r); chk("R12 clear zero", r, 7);
    acc(2'b10, 12'h342, 0, r); chk("R12 set zero", r, 7);
    m_cau = 7;
    // R5 / R8 epc alignment
    acc(2'b01, 12'h341, 32'h1234_5677, r);
    acc(2'b00, 12'h341, 0, r); chk("R5 epc aligned", r, 32'h1234_5674);
    chk("R8 resume_pc", resume_pc, 32'h1234_5674);
    acc(2'b10, 12'h341, 32'h0000_0003, r);
    acc(2'b00, 12'h341, 0, r); chk("R5 epc set low bits", r, 32'h1234_5674);
    m_epc = 32'h1234_5674;
    // R3 vector
    chk("R3 trap_vector port", trap_vector, 32'h100);
    acc(2'b01, 12'h305, 32'hDEAD_BEEF, r); chk("R3 vec read", r, 32'h100);
    acc(2'b00, 12'h305, 0, r); chk("R3 vec after write", r, 32'h100);
    // R2 sweep: write ones to every non-implemented address, read back zero
    for (int a = 0; a < 4096; a++) begin
      if (!is_impl(a[11:0])) begin
        acc(2'b01, a[11:0], 32'hFFFF_FFFF, r);
        chk("R2 unimpl read", r, 0);
      end
    end
    acc(2'b00, 12'h340, 0, r); chk("R2 scratch untouched", r, m_scr);
    acc(2'b00, 12'h341, 0, r); chk("R2 epc untouched", r, m_epc);
    acc(2'b00, 12'h342, 0, r); chk("R2 cause untouched", r, m_cau);
    acc(2'b00, 12'h343, 0, r); chk("R2 tval untouched", r, m_tval);
    // R9 shared counter, consecutive reads
    acc(2'b00, 12'hC00, 0, r);
    acc(2'b00, 12'hC01, 0, r2); chk("R9 time = cycle+1", r2, r + 1);
    acc(2'b01, 12'hC00, 32'h0, r3); chk("R9 cycle+2", r3, r + 2);
    acc(2'b00, 12'hC00, 0, r2); chk("R11 cycle write ignored", r2, r + 3);
    acc(2'b00, 12'hC80, 0, r); chk("R9 cycle hi", r, 0);
    acc(2'b00, 12'hC81, 0, r); chk("R9 time hi", r, 0);
    // R10 / R11 retire
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      retire = 1; csr_en = 1; csr_op = 0; csr_addr = 12'hC02;
      #1 chk("R11 instret pre-increment", csr_rdata, k);
      @(posedge clk); #0.5 retire = 0; csr_en = 0;
      acc(2'b00, 12'hC02, 0, r); chk("R10 instret step", r, k + 1);
    end
    acc(2'b01, 12'hC02, 32'h55, r);
    acc(2'b00, 12'hC02, 0, r); chk("R11 instret write ignored", r, 5);
    // R6 trap capture
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      trap_valid = 1; trap_pc = 32'h8000_0001 + 32'(t) * 32'h111;
      trap_cause = 32'(t + 2); trap_tval = 32'hC0DE_0000 + 32'(t);
      @(posedge clk); #0.5 trap_valid = 0;
      m_epc = {trap_pc[31:2], 2'b00};
      acc(2'b00, 12'h341, 0, r); chk("R6 epc", r, m_epc);
      chk("R8 resume after trap", resume_pc, m_epc);
      acc(2'b00, 12'h342, 0, r); chk("R6 cause", r, 32'(t + 2));
      acc(2'b00, 12'h343, 0, r); chk("R6 tval", r, 32'hC0DE_0000 + 32'(t));
    end
    // R7 collision: trap and software write in the same cycle
    for (int a = 12'h341; a <= 12'h343; a++) begin
      @(negedge clk);
      trap_valid = 1; trap_pc = 32'h0000_4008; trap_cause = 32'd11; trap_tval = 32'h0000_0BAD;
      csr_en = 1; csr_op = 2'b01; csr_addr = a[11:0]; csr_wdata = 32'h7777_7777;
      @(posedge clk); #0.5 trap_valid = 0; csr_en = 0; csr_op = 0;
      acc(2'b00, 12'h341, 0, r); chk("R7 epc wins", r, 32'h0000_4008);
      acc(2'b00, 12'h342, 0, r); chk("R7 cause wins", r, 11);
      acc(2'b00, 12'h343, 0, r); chk("R7 tval wins", r, 32'h0000_0BAD);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule